// File: doc/BRIEF.md
# Packet-Locked Output Port Arbiter

This block decides, for one output port of a network router, which source drives the port. Up to five sources compete: a bypass path that carries flits straight through without buffering, a straight-path buffer, and up to three turn-path buffers. The grant is locked to one packet. It is taken when a header flit is chosen and released only after the matching tail flit has left. A new choice is made only while the port is idle.

An external controller sets the port mode. In bypass mode only the bypass can win. In buffer mode the buffers share the port in round-robin order. A one-cycle post-transition flag, raised right after a switch into buffer mode, gives the straight-path buffer first claim, so that a packet begun on the bypass is finished before anything else. A downstream off signal stops all buffer reads. If off arrives while the bypass holds the port, or buffer mode is entered during a bypass packet, the grant moves to the straight-path buffer at once. The remainder of that packet is then read from the straight-path buffer.

Each source presents the kind of its front flit as a two-bit code: 00 none, 01 header, 10 body, 11 tail.

Top module: `pkt_out_arbiter`

## Requirements
- R1: During and right after reset, `grant` is all zeros and every bit of `rd_en` is low.
- R2: In bypass mode (`mode_buf`=0), an idle port whose bypass shows a header (01) with `off` low sets `grant` to bit 0 on the next clock. Buffer contents never cause a grant in bypass mode.
- R3: In buffer mode, an idle port grants on the next clock the first buffer whose front flit is a header (01), searching upward from the round-robin pointer and wrapping. Buffer j maps to `grant` bit j+1, and buffer 0 is the straight path.
- R4: The round-robin pointer becomes one past buffer j (wrapping to 0) only in the cycle a tail flit (11) is read from buffer j. Otherwise it holds. After reset it points at buffer 0.
- R5: When `mode_changed` is high in buffer mode with the port idle and buffer 0 showing a header, buffer 0 is granted regardless of the pointer.
- R6: Once granted, `grant` keeps its value until a tail flit of that packet is sent, and goes to zero on the next clock. No new arbitration happens while `grant` is nonzero.
- R7: While the bypass holds the grant, `off` high or `mode_buf` high moves `grant` to bit 1 (straight-path buffer) on the next clock, with no tail required.
- R8: While `off` is high, every bit of `rd_en` is low.
- R9: `grant` never has more than one bit set.
- R10: In the same cycle, `rd_en[j]` is high exactly when `grant` bit j+1 is set, buffer j is non-empty and `off` is low. A bypass flit counts as sent when bit 0 is granted, its kind is not 00, `off` is low and `mode_buf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_buf | input | 1 | 0 = bypass mode, 1 = buffer mode |
| mode_changed | input | 1 | One-cycle flag right after entering buffer mode |
| off | input | 1 | Downstream stop request |
| byp_kind | input | 2 | Front flit kind on the bypass |
| buf_nonempty | input | NUM_TURN+1 | Per-buffer non-empty flag, bit 0 straight |
| buf_kind | input | 2*(NUM_TURN+1) | Front flit kind per buffer, buffer j at bits 2j+1:2j |
| grant | output | NUM_TURN+2 | Registered one-hot source select, bit 0 bypass |
| rd_en | output | NUM_TURN+1 | Per-buffer read enable |

## Verification
A corrupted lock or grant register appears at `grant` on the very next clock. Typical symptoms are a second bit set, a source change in mid-packet, or a port that stays busy after a tail. A wrong round-robin pointer stays hidden until the next idle arbitration in which two or more buffers hold headers, so the bench keeps several buffers loaded across successive packets. A wrong read gate shows as a read enable during `off` or on an ungranted buffer in the same cycle. A reference model compares both outputs every cycle, which catches each of these as soon as it becomes visible.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;
  localparam logic [1:0] FK_NONE = 2'd0;
  localparam logic [1:0] FK_HEAD = 2'd1;
  localparam logic [1:0] FK_BODY = 2'd2;
  localparam logic [1:0] FK_TAIL = 2'd3;
  localparam int MAX_BUF = 16;

  // First set bit at or after start, wrapping; -1 when none.
  function automatic int rr_first(input logic [MAX_BUF-1:0] req, input int start, input int n);
    int hit;
    int idx;
    hit = -1;
    for (int k = n - 1; k >= 0; k--) begin
      idx = (start + k) % n;
      if (req[idx]) hit = idx;
    end
    return hit;
  endfunction

  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  function automatic int onehot_index(input logic [MAX_BUF-1:0] v, input int n);
    int r;
    r = 0;
    for (int k = 0; k < n; k++) if (v[k]) r = k;
    return r;
  endfunction
endpackage

// File: rtl/pkt_arb_pick.sv
module pkt_arb_pick import pkt_arb_pkg::*; #(
  parameter int NBUF = 4,
  localparam int NSRC = NBUF + 1,
  localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              mode_buf,
  input  logic              mode_changed,
  input  logic              off,
  input  logic [1:0]        byp_kind,
  input  logic [NBUF-1:0]   buf_nonempty,
  input  logic [2*NBUF-1:0] buf_kind,
  input  logic [PTR_W-1:0]  rr_ptr,
  output logic [NSRC-1:0]   pick
);
  logic [NBUF-1:0]    head_req;
  logic [MAX_BUF-1:0] req_wide;
  int                 rr_hit;

  for (genvar j = 0; j < NBUF; j++) begin : g_req
    assign head_req[j] = buf_nonempty[j] && (buf_kind[2*j +: 2] == FK_HEAD);
  end
  assign req_wide = MAX_BUF'(head_req);

  always_comb begin
    pick   = '0;
    rr_hit = rr_first(req_wide, int'(rr_ptr), NBUF);
    if (!mode_buf) begin
      pick[0] = (byp_kind == FK_HEAD) && !off;
    end else if (mode_changed && head_req[0]) begin
      pick[1] = 1'b1;
    end else if (rr_hit >= 0) begin
      pick[rr_hit + 1] = 1'b1;
    end
  end
endmodule

// File: rtl/pkt_arb_rrptr.sv
module pkt_arb_rrptr import pkt_arb_pkg::*; #(
  parameter int NBUF = 4,
  localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [PTR_W-1:0] adv_idx,
  output logic [PTR_W-1:0] rr_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   rr_ptr <= '0;
    else if (adv) rr_ptr <= PTR_W'(wrap_inc(int'(adv_idx), NBUF));
  end

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(rr_ptr));
endmodule

// File: rtl/pkt_arb_lock.sv
module pkt_arb_lock #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pick,
  input  logic            handoff,
  input  logic            tail_sent,
  output logic [NSRC-1:0] grant
);
  always_ff @(posedge clk) begin
    if (!rst_n)              grant <= '0;
    else if (grant == '0) begin
      if (|pick)             grant <= pick;
    end else if (handoff)    grant <= NSRC'(2);
    else if (tail_sent)      grant <= '0;
  end

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !handoff && !tail_sent) |=> (grant == $past(grant)));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !handoff && tail_sent) |=> (grant == '0));
endmodule

// File: rtl/pkt_out_arbiter.sv
module pkt_out_arbiter import pkt_arb_pkg::*; #(
  parameter int NUM_TURN = 3,
  localparam int NBUF = NUM_TURN + 1,
  localparam int NSRC = NBUF + 1,
  localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_buf,
  input  logic              mode_changed,
  input  logic              off,
  input  logic [1:0]        byp_kind,
  input  logic [NBUF-1:0]   buf_nonempty,
  input  logic [2*NBUF-1:0] buf_kind,
  output logic [NSRC-1:0]   grant,
  output logic [NBUF-1:0]   rd_en
);
  logic [NSRC-1:0]  pick;
  logic [PTR_W-1:0] rr_ptr;
  logic [PTR_W-1:0] adv_idx;
  logic [NBUF-1:0]  buf_tail;
  logic             byp_sent;
  logic             byp_tail_sent;
  logic             buf_tail_sent;
  logic             tail_sent;
  logic             handoff;

  for (genvar j = 0; j < NBUF; j++) begin : g_gate
    assign buf_tail[j] = (buf_kind[2*j +: 2] == FK_TAIL);
    assign rd_en[j]    = grant[j+1] && buf_nonempty[j] && !off;
  end

  assign byp_sent      = grant[0] && (byp_kind != FK_NONE) && !off && !mode_buf;
  assign byp_tail_sent = byp_sent && (byp_kind == FK_TAIL);
  assign buf_tail_sent = |(rd_en & buf_tail);
  assign tail_sent     = byp_tail_sent || buf_tail_sent;
  assign handoff       = grant[0] && (off || mode_buf);
  assign adv_idx       = PTR_W'(onehot_index(MAX_BUF'(grant[NSRC-1:1]), NBUF));

  pkt_arb_pick #(.NBUF(NBUF)) pick_i (
    .mode_buf(mode_buf), .mode_changed(mode_changed), .off(off),
    .byp_kind(byp_kind), .buf_nonempty(buf_nonempty), .buf_kind(buf_kind),
    .rr_ptr(rr_ptr), .pick(pick)
  );

  pkt_arb_rrptr #(.NBUF(NBUF)) rr_i (
    .clk(clk), .rst_n(rst_n), .adv(buf_tail_sent), .adv_idx(adv_idx), .rr_ptr(rr_ptr)
  );

  pkt_arb_lock #(.NSRC(NSRC)) lock_i (
    .clk(clk), .rst_n(rst_n), .pick(pick), .handoff(handoff),
    .tail_sent(tail_sent), .grant(grant)
  );

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_no_read_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> (rd_en == '0));
  assert_read_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & ~grant[NSRC-1:1]) == '0);
  assert_bypass_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_buf && grant == '0 && byp_kind == FK_HEAD && !off) |=> grant[0]);
  assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[0] && (off || mode_buf)) |=> (grant == NSRC'(2)));
  assert_straight_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_buf && mode_changed && grant == '0 && buf_nonempty[0] && buf_kind[1:0] == FK_HEAD)
      |=> grant[1]);
endmodule

// File: tb/pkt_out_arbiter_tb_top.sv
`timescale 1ns/1ps
module pkt_out_arbiter_tb_top;
  localparam int NT   = 3;
  localparam int NB   = NT + 1;
  localparam int NS   = NB + 1;
  localparam int HEAD = 1, BODY = 2, TAIL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_buf = 1'b0, mode_changed = 1'b0, off = 1'b0;
  logic [1:0] byp_kind = '0;
  logic [NB-1:0] buf_nonempty = '0;
  logic [2*NB-1:0] buf_kind = '0;
  logic [NS-1:0] grant;
  logic [NB-1:0] rd_en;

  int checks = 0, fails = 0;
  string tag = "R1";
  int byp_q[$];
  int bq[NB][$];
  int mg = -1;
  int mptr = 0;

  always #10 clk = ~clk;

  pkt_out_arbiter #(.NUM_TURN(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .mode_changed(mode_changed),
    .off(off), .byp_kind(byp_kind), .buf_nonempty(buf_nonempty), .buf_kind(buf_kind),
    .grant(grant), .rd_en(rd_en)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit m_rd(input int j);
    return (mg == j + 1) && (bq[j].size() > 0) && !off;
  endfunction

  task automatic drive();
    byp_kind = (byp_q.size() > 0) ? 2'(byp_q[0]) : 2'd0;
    for (int j = 0; j < NB; j++) begin
      buf_nonempty[j]     = bq[j].size() > 0;
      buf_kind[2*j +: 2]  = (bq[j].size() > 0) ? 2'(bq[j][0]) : 2'd0;
    end
  endtask

  task automatic model_update();
    bit sent_byp;
    bit rd[NB];
    int bk;
    bit found;
    int idx;
    sent_byp = (mg == 0) && (byp_q.size() > 0) && !off && !mode_buf;
    for (int j = 0; j < NB; j++) rd[j] = m_rd(j);
    bk = (byp_q.size() > 0) ? byp_q[0] : 0;
    if (!rst_n) begin
      mg = -1; mptr = 0;
    end else if (mg < 0) begin
      if (!mode_buf) begin
        if (bk == HEAD && !off) mg = 0;
      end else if (mode_changed && bq[0].size() > 0 && bq[0][0] == HEAD) begin
        mg = 1;
      end else begin
        found = 0;
        for (int k = 0; k < NB; k++) begin
          idx = (mptr + k) % NB;
          if (!found && bq[idx].size() > 0 && bq[idx][0] == HEAD) begin
            found = 1; mg = idx + 1;
          end
        end
      end
    end else if (mg == 0) begin
      if (off || mode_buf) begin
        mg = 1;
        while (byp_q.size() > 0) bq[0].push_back(byp_q.pop_front());
      end else if (sent_byp && bk == TAIL) mg = -1;
    end else begin
      if (rd[mg-1] && bq[mg-1][0] == TAIL) begin
        mptr = (mg % NB);
        mg = -1;
      end
    end
    if (sent_byp && byp_q.size() > 0) void'(byp_q.pop_front());
    for (int j = 0; j < NB; j++) if (rd[j]) void'(bq[j].pop_front());
  endtask

  task automatic run(input int n);
    int exp_g;
    int exp_r;
    for (int c = 0; c < n; c++) begin
      drive();
      #1;
      exp_r = 0;
      for (int j = 0; j < NB; j++) if (m_rd(j)) exp_r |= (1 << j);
      chk(int'(rd_en) == exp_r, off ? "R8" : "R10", "rd_en", int'(rd_en), exp_r);
      @(negedge clk);
      model_update();
      exp_g = (mg < 0) ? 0 : (1 << mg);
      chk(int'(grant) == exp_g, tag, "grant", int'(grant), exp_g);
      chk($countones(grant) <= 1, "R9", "grant bits", $countones(grant), 1);
    end
  endtask

  task automatic pkt(input int src, input int bodies);
    if (src < 0) begin
      byp_q.push_back(HEAD);
      for (int b = 0; b < bodies; b++) byp_q.push_back(BODY);
      byp_q.push_back(TAIL);
    end else begin
      bq[src].push_back(HEAD);
      for (int b = 0; b < bodies; b++) bq[src].push_back(BODY);
      bq[src].push_back(TAIL);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    run(3);
    chk(grant == '0 && rd_en == '0, "R1", "reset outputs", int'(grant), 0);
    rst_n = 1'b1;

    // R2: bypass packet, buffers loaded but ignored in bypass mode
    tag = "R2";
    pkt(2, 1);
    pkt(-1, 2);
    run(8);
    chk(bq[2].size() == 3 && grant == '0, "R2", "buffer untouched in bypass mode", bq[2].size(), 3);

    // R7: off while bypass holds the port, rest drains from straight buffer
    tag = "R7";
    pkt(-1, 4);
    run(3);
    off = 1'b1;
    run(1);
    chk(grant == NS'(2), "R7", "handoff to straight", int'(grant), 2);
    run(1);
    off = 1'b0; mode_buf = 1'b1;
    run(10);

    // R3/R4: round robin across several loaded buffers
    tag = "R3";
    pkt(1, 1); pkt(3, 0); pkt(0, 2); pkt(2, 1);
    run(20);
    tag = "R4";
    pkt(3, 1); pkt(0, 0); pkt(1, 1);
    run(16);

    // R5: straight buffer first after mode change
    tag = "R5";
    mode_buf = 1'b0;
    pkt(2, 1); pkt(3, 0); pkt(0, 1);
    run(3);
    mode_buf = 1'b1; mode_changed = 1'b1;
    run(1);
    chk(grant == NS'(2), "R5", "straight first", int'(grant), 2);
    mode_changed = 1'b0;
    run(16);

    // R8/R6: off stalls reads in buffer mode, lock held through stall
    tag = "R6";
    pkt(1, 3); pkt(2, 0);
    run(3);
    off = 1'b1;
    run(3);
    chk(rd_en == '0, "R8", "no reads under off", int'(rd_en), 0);
    off = 1'b0;
    run(14);
    chk(grant == '0, "R6", "idle after drain", int'(grant), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule